// File: doc/BRIEF.md
# Single-Access Load/Store Address and Alignment Unit

This unit sits between a processor's execute stage and a 32-bit little-endian data bus. For one load or store at a time, it adds a base value to an offset to form the effective address. The offset is either a register value, a small immediate scaled by the access size, or an 8-bit word immediate. The base is either a register value or a word-aligned program counter plus four. The unit then checks that the address suits the access size. An aligned access drives a request on the bus with byte strobes and with the store data copied onto the right lanes. A misaligned access never reaches the bus. It produces a one-cycle fault pulse instead.

A load returns its data one cycle after the bus response. The unit takes the addressed byte or halfword out of the read word and then zero-extends or sign-extends it as requested. The unit handles one access at a time. While it is busy, new requests are ignored.

Top module: `lsu_addr_align`

## Requirements
- R1: With `addr_mode` 2'b00 the effective address is `base_val + off_reg`, for byte, halfword and word accesses alike.
- R2: With `addr_mode` 2'b01 the address is `base_val` plus `imm_val[4:0]` zero-extended and shifted left by 2 for a word, by 1 for a halfword and by 0 for a byte. Size codes: 2'b00 byte, 2'b01 halfword, 2'b10 or 2'b11 word.
- R3: With `addr_mode` 2'b10 (stack-relative) the access is always a word at `base_val + (imm_val << 2)`, and it may be a load or a store.
- R4: With `addr_mode` 2'b11 (literal) the access is always a word load at `((pc_val + 4) & ~3) + (imm_val << 2)`, and `is_store` is ignored.
- R5: `mem_be` is 4'b1111 for a word. For a halfword it is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. For a byte it is `4'b0001 << addr[1:0]`. `mem_wdata` repeats the store byte four times, the store halfword twice, or carries the word as is.
- R6: A halfword at an odd address, or a word whose address has nonzero bits [1:0], raises `fault` for exactly one cycle, in the cycle after the request. `mem_req` is not raised for that access.
- R7: One cycle after the cycle in which `mem_ack` is high, `done` pulses for one cycle. For a load, `load_data` then holds the lane picked by the low address bits. Byte and halfword values are sign-extended when `is_signed` is 1 and zero-extended when it is 0.
- R8: `mem_req` rises in the cycle after an aligned request. It stays high with `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is high, and it is low in the following cycle.
- R9: A `req_valid` pulse while `busy` is high has no effect on the access in flight.
- R10: After reset, `mem_req`, `fault`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| addr_mode | input | 2 | Addressing form select |
| acc_size | input | 2 | Access size |
| is_signed | input | 1 | Sign-extend a byte or halfword load |
| is_store | input | 1 | 1 for a store, 0 for a load |
| base_val | input | 32 | Base register or stack pointer value |
| off_reg | input | 32 | Offset register value |
| imm_val | input | 8 | Immediate offset (low 5 bits in mode 2'b01) |
| pc_val | input | 32 | Address of the current instruction |
| st_data | input | 32 | Store data, right-aligned |
| busy | output | 1 | An access is in progress |
| fault | output | 1 | Misaligned access pulse |
| done | output | 1 | Access complete pulse |
| load_data | output | 32 | Formatted load result |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write enable |
| mem_addr | output | 32 | Bus address |
| mem_be | output | 4 | Byte strobes |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Bus response |
| mem_rdata | input | 32 | Bus read data, valid with mem_ack |

## Verification
A wrong latched size or address would show up on `mem_be` and `mem_addr` in the very first cycle of `mem_req`. A wrong lane choice or wrong extension would show up on `load_data` in the cycle after the response. A broken sequencer would show up in one of three ways: a request that outlives `mem_ack`, a fault that lasts two cycles, or a misaligned access that raises `mem_req`. Each of these is visible within one or two cycles of the event that caused it. The bench watches `busy` and `mem_addr` straight after an ignored request pulse, so a state change caused by that pulse is caught at once.

// File: rtl/lsu_addr_align.sv
module lsu_addr_align (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  addr_mode,
  input  logic [1:0]  acc_size,
  input  logic        is_signed,
  input  logic        is_store,
  input  logic [31:0] base_val,
  input  logic [31:0] off_reg,
  input  logic [7:0]  imm_val,
  input  logic [31:0] pc_val,
  input  logic [31:0] st_data,
  output logic        busy,
  output logic        fault,
  output logic        done,
  output logic [31:0] load_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_FLT, S_DONE} state_t;
  state_t state;

  wire       word_only = addr_mode[1];
  wire [1:0] sz = (word_only || acc_size == 2'd3) ? 2'd2 : acc_size;
  wire       wr = is_store && (addr_mode != 2'b11);

  logic [31:0] off, basev, ea;
  logic [3:0]  be;
  logic [31:0] wd;

  always_comb begin
    case (addr_mode)
      2'b00:   off = off_reg;
      2'b01:   off = (sz == 2'd2) ? {25'd0, imm_val[4:0], 2'b00} :
                     (sz == 2'd1) ? {26'd0, imm_val[4:0], 1'b0} :
                                    {27'd0, imm_val[4:0]};
      default: off = {22'd0, imm_val, 2'b00};
    endcase
  end

  assign basev = (addr_mode == 2'b11) ? ((pc_val + 32'd4) & ~32'd3) : base_val;
  assign ea    = basev + off;

  wire misal = (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'b00);

  always_comb begin
    case (sz)
      2'd0:    begin be = 4'b0001 << ea[1:0];             wd = {4{st_data[7:0]}};  end
      2'd1:    begin be = ea[1] ? 4'b1100 : 4'b0011;      wd = {2{st_data[15:0]}}; end
      default: begin be = 4'b1111;                        wd = st_data;            end
    endcase
  end

  logic [1:0] sz_q;
  logic       sgn_q;

  logic [7:0]  rd_b;
  logic [15:0] rd_h;
  logic [31:0] fmt;
  assign rd_b = mem_rdata >> {mem_addr[1:0], 3'b000};
  assign rd_h = mem_addr[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    case (sz_q)
      2'd0:    fmt = {{24{sgn_q & rd_b[7]}}, rd_b};
      2'd1:    fmt = {{16{sgn_q & rd_h[15]}}, rd_h};
      default: fmt = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      sz_q      <= '0;
      sgn_q     <= 1'b0;
      load_data <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          if (misal) state <= S_FLT;
          else begin
            state     <= S_BUS;
            mem_addr  <= ea;
            mem_be    <= be;
            mem_we    <= wr;
            mem_wdata <= wr ? wd : '0;
            sz_q      <= sz;
            sgn_q     <= is_signed;
          end
        end
        S_BUS: if (mem_ack) begin
          state     <= S_DONE;
          load_data <= mem_we ? '0 : fmt;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = state != S_IDLE;
  assign mem_req = state == S_BUS;
  assign fault   = state == S_FLT;
  assign done    = state == S_DONE;

endmodule

// File: rtl/lsu_addr_align_chk.sv
module lsu_addr_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        fault,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);

  a_r6_no_req_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_req);

  a_r6_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                               && $stable(mem_we) && $stable(mem_wdata)));

  a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  a_r7_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> done);

  a_r5_strobe_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_be == 4'b1111 && mem_addr[1:0] == 2'b00) ||
                 (mem_be == 4'b0011 && mem_addr[1:0] == 2'b00) ||
                 (mem_be == 4'b1100 && mem_addr[1:0] == 2'b10) ||
                 ($countones(mem_be) == 1 && mem_be == (4'b0001 << mem_addr[1:0]))));

  a_r9_busy_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && req_valid) |=> (mem_req && $stable(mem_addr)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !fault && !done));

endmodule

bind lsu_addr_align lsu_addr_align_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .fault(fault),
  .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/test_lsu_addr_align.sv
`timescale 1ns/1ps
module test_lsu_addr_align;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, is_signed = 0, is_store = 0, mem_ack = 0;
  logic [1:0] addr_mode = 0, acc_size = 0;
  logic [31:0] base_val = 0, off_reg = 0, pc_val = 0, st_data = 0, mem_rdata = 0;
  logic [7:0] imm_val = 0;
  logic busy, fault, done, mem_req, mem_we;
  logic [31:0] load_data, mem_addr, mem_wdata;
  logic [3:0] mem_be;
  int checks = 0, fails = 0;
  int seed = 32'h5a17;

  always #5 clk = ~clk;

  lsu_addr_align i_lsu_addr_align (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] e_sz(input logic [1:0] m, input logic [1:0] s);
    return (m[1] || s == 2'd3) ? 2'd2 : s;
  endfunction

  function automatic logic [31:0] e_addr(input logic [1:0] m, input logic [1:0] s,
      input logic [31:0] b, input logic [31:0] o, input logic [7:0] im, input logic [31:0] pc);
    logic [31:0] imm5 = {27'd0, im[4:0]};
    case (m)
      2'b00: return b + o;
      2'b01: return b + (imm5 << (e_sz(m, s) == 2'd2 ? 2 : e_sz(m, s) == 2'd1 ? 1 : 0));
      2'b10: return b + ({24'd0, im} * 4);
      default: return (((pc + 4) / 4) * 4) + ({24'd0, im} * 4);
    endcase
  endfunction

  function automatic logic [3:0] e_be(input logic [1:0] s, input logic [31:0] a);
    case (s)
      2'd0: return 4'b0001 << a[1:0];
      2'd1: return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] e_wd(input logic [1:0] s, input logic [31:0] d);
    case (s)
      2'd0: return {d[7:0], d[7:0], d[7:0], d[7:0]};
      2'd1: return {d[15:0], d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] e_ld(input logic [1:0] s, input logic sg,
      input logic [31:0] a, input logic [31:0] r);
    logic [7:0] b8; logic [15:0] h16;
    b8 = r[8*a[1:0] +: 8];
    h16 = r[16*a[1] +: 16];
    case (s)
      2'd0: return sg ? {{24{b8[7]}}, b8} : {24'd0, b8};
      2'd1: return sg ? {{16{h16[15]}}, h16} : {16'd0, h16};
      default: return r;
    endcase
  endfunction

  task automatic access(input logic [1:0] m, input logic [1:0] s, input logic sg,
      input logic st, input logic [31:0] b, input logic [31:0] o, input logic [7:0] im,
      input logic [31:0] pc, input logic [31:0] d, input logic [31:0] rd, input int waits,
      input logic inject);
    logic [1:0] es = e_sz(m, s);
    logic [31:0] ea = e_addr(m, s, b, o, im, pc);
    logic ew = st && (m != 2'b11);
    logic mis = (es == 2'd1 && ea[0]) || (es == 2'd2 && ea[1:0] != 0);
    string rq = m == 2'b00 ? "R1" : m == 2'b01 ? "R2" : m == 2'b10 ? "R3" : "R4";
    @(negedge clk);
    addr_mode = m; acc_size = s; is_signed = sg; is_store = st; base_val = b;
    off_reg = o; imm_val = im; pc_val = pc; st_data = d; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (mis) begin
      chk(fault, 1, "R6 fault");
      chk(mem_req, 0, "R6 no request");
      @(negedge clk);
      chk(fault, 0, "R6 single pulse");
      chk(busy, 0, "R6 back to idle");
      return;
    end
    chk(fault, 0, "R6 aligned no fault");
    chk(mem_req, 1, "R8 request");
    chk(mem_addr, ea, rq);
    chk(mem_be, e_be(es, ea), "R5 strobes");
    chk(mem_we, ew, m == 2'b11 ? "R4 load only" : "R3 write enable");
    if (ew) chk(mem_wdata, e_wd(es, d), "R5 store lanes");
    for (int i = 0; i < waits; i++) begin
      if (inject) begin
        base_val = ~b; off_reg = o + 32'h40; addr_mode = 2'b00; req_valid = 1;
      end
      @(negedge clk);
      req_valid = 0;
      chk(mem_req, 1, "R8 held");
      chk(mem_addr, ea, inject ? "R9 ignored while busy" : "R8 stable address");
    end
    mem_ack = 1; mem_rdata = rd;
    @(negedge clk);
    mem_ack = 0;
    chk(mem_req, 0, "R8 drop after ack");
    chk(done, 1, "R7 done");
    if (!ew) chk(load_data, e_ld(es, sg, ea, rd), "R7 load format");
    @(negedge clk);
    chk(done, 0, "R7 done pulse");
    chk(busy, 0, "R9 idle after access");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    #23;
    chk(mem_req, 0, "R10 reset req");
    chk(fault, 0, "R10 reset fault");
    chk(done, 0, "R10 reset done");
    chk(busy, 0, "R10 reset busy");
    rst_n = 1;
    // directed corner cases
    access(2'b11, 2'd0, 0, 1, 0, 0, 8'd1, 32'h1002, 0, 32'hcafe_f00d, 1, 0); // R4: 0x1008
    access(2'b01, 2'd1, 0, 0, 32'h100, 0, 8'd5, 0, 0, 32'h8765_4321, 0, 0);  // R2: 0x10a
    access(2'b10, 2'd0, 0, 1, 32'h2000, 0, 8'hff, 0, 32'h1122_3344, 0, 0, 0); // R3
    access(2'b00, 2'd0, 1, 0, 32'h3, 0, 0, 0, 0, 32'h80ff_ffff, 2, 1);        // R7 sign byte
    access(2'b00, 2'd1, 1, 0, 32'h2, 0, 0, 0, 0, 32'h8001_7fff, 0, 0);        // R7 sign half
    access(2'b00, 2'd1, 0, 0, 32'h1, 0, 0, 0, 0, 0, 0, 0);                   // R6 odd half
    access(2'b01, 2'd2, 0, 1, 32'h2, 0, 8'd3, 0, 0, 0, 0, 0);                // R6 word
    access(2'b00, 2'd0, 0, 1, 32'h1, 32'h1, 0, 0, 32'hab, 0, 0, 0);          // R5 byte lane 2
    for (int n = 0; n < 400; n++) begin
      logic [31:0] b = $urandom, o = $urandom;
      if ($urandom % 2) begin b[1:0] = 0; o[1:0] = 0; end
      access(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), b, o,
             8'($urandom), $urandom, $urandom, $urandom, $urandom % 3, 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule